// File: doc/BRIEF.md
# Decrementing Timer with Edge-Triggered Interrupt Request

This block is a down-counter that software loads through a write port and reads back through a read port. Each pulse on the timebase tick input lowers the count by one. When the count passes through zero, it wraps to all ones. The counter's top bit then goes from 0 to 1, and that edge sets a pending interrupt flag.

The flag is not derived from the count by comparison. It is latched and stays set until the exception arbiter acknowledges it. The request output shows the pending flag only while the external-interrupt enable input is high. While the enable is low the flag is kept, and it appears as soon as the enable returns. The request is maskable and asynchronous to instruction flow. The arbiter ranks it below the external interrupt.

A software write can also raise the flag. This happens when the written value has its top bit set and the count held before the write had it clear. The counter width is a parameter and is 32 bits by default.

Top module: `dcount_irq`

## Requirements
- R1: While reset is asserted and after it is released, the count reads 0 and the request output is 0.
- R2: A write with `wr_en` high loads `wr_data` into the count on that clock edge, and `rd_data` returns the current count.
- R3: With `wr_en` low, a high `tick` lowers the count by exactly one per edge, and a low `tick` leaves the count unchanged.
- R4: A tick at count 0 wraps the count to all ones, which sets the pending flag.
- R5: A write sets the pending flag only when the top bit of the count goes from 0 to 1 across that write. A write that leaves the top bit at 1 does not set it.
- R6: A decrement that clears the top bit does not set the pending flag, and neither does one that leaves the top bit unchanged. An example of the first is 0x80000000 to 0x7FFFFFFF.
- R7: `irq_req` equals the pending flag while `ext_en` is 1 and is 0 while `ext_en` is 0. A masked flag stays pending.
- R8: Only `ack` clears the pending flag. An `ack` while nothing is pending has no effect. A new top-bit edge in the same cycle as `ack` leaves the flag set.
- R9: When `wr_en` and `tick` are both high, the write wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | CNT_W | Value to load |
| rd_data | output | CNT_W | Current count |
| tick | input | 1 | Timebase pulse, one decrement per high cycle |
| ext_en | input | 1 | External-interrupt enable; gates the request |
| ack | input | 1 | Acknowledge from the exception arbiter; clears the pending flag |
| irq_req | output | 1 | Interrupt request to the arbiter |

## Verification
The bench builds the block at its default width of 32 bits. At this width the full wrap from zero to 0xFFFFFFFF happens. The 0x80000000 boundary is reached by loading values next to it, so no long count-down is needed. Each edge case then costs only a handful of cycles: the wrap, the top-bit fall, a write that crosses into the top half, and ack colliding with a fresh edge.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  // Source selected for the next count value
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_STEP = 2'd2
  } upd_e;

  // Rising transition of a single bit between two successive values
  function automatic logic bit_rises(input logic before_v, input logic after_v);
    return (!before_v) && after_v;
  endfunction

  // Pending-flag update: a fresh edge dominates an acknowledge
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/dcnt_counter.sv
module dcnt_counter
  import dcnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  upd_e sel;

  always_comb begin
    if (ld)        sel = UPD_LOAD;
    else if (step) sel = UPD_STEP;
    else           sel = UPD_HOLD;
  end

  always_comb begin
    unique case (sel)
      UPD_LOAD: cnt_d = ld_val;
      UPD_STEP: cnt_d = step_down(cnt_q);
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a write lands on the next edge
  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));

  // R3: one tick, one unit down
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld) |=> (cnt_q == $past(cnt_q) - ONE));

  // R3: idle holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/dcnt_msb_edge.sv
module dcnt_msb_edge
  import dcnt_pkg::*;
(
  input  logic cur_msb,
  input  logic nxt_msb,
  output logic rise
);

  always_comb rise = bit_rises(cur_msb, nxt_msb);

endmodule

// File: rtl/dcnt_pending.sv
module dcnt_pending
  import dcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next(pend, set, clr);
  end

  // R8: acknowledge without a fresh edge empties the flag
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);

  // R8: a fresh edge wins over acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);

  // R8: nothing but acknowledge lowers the flag
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

endmodule

// File: rtl/dcount_irq.sv
module dcount_irq
  import dcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tick,
  input  logic             ext_en,
  input  logic             ack,
  output logic             irq_req
);

  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             msb_edge;
  logic             irq_pending;

  dcnt_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (wr_en),
    .ld_val (wr_data),
    .step   (tick),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d)
  );

  dcnt_msb_edge u_edge (
    .cur_msb (cnt_q[MSB]),
    .nxt_msb (cnt_d[MSB]),
    .rise    (msb_edge)
  );

  dcnt_pending u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (msb_edge),
    .clr   (ack),
    .pend  (irq_pending)
  );

  always_comb rd_data = cnt_q;
  always_comb irq_req = irq_pending & ext_en;

  // R4: tick at zero wraps to all ones and latches the flag
  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && tick && !wr_en) |=> (irq_pending && (&cnt_q)));

  // R6: a falling top bit never raises the flag on its own
  a_r6_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && cnt_q[MSB] && !wr_en) |=> !irq_pending);

  // R7: masking keeps the flag pending
  a_r7_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && irq_pending && !ack) |=> irq_pending);

  // R1: reset state
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!irq_req && cnt_q == '0));

endmodule

// File: tb/tb_dcount_irq.sv
module tb_dcount_irq;

  localparam int W = 32;

  typedef struct packed {
    logic         we;
    logic [W-1:0] wd;
    logic         tk;
    logic         en;
    logic         ak;
    logic [W-1:0] exp_cnt;
    logic         exp_irq;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 32'h0000_0005, 1'b0, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 4'd2}, // R2 load
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0004, 1'b0, 4'd3}, // R3 step
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_0004, 1'b0, 4'd3}, // R3 hold
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0003, 1'b0, 4'd3},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0002, 1'b0, 4'd3},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0001, 1'b0, 4'd3},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 4'd3},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'd4}, // R4 wrap
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 4'd7}, // R7 masked
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'd7}, // R7 unmasked
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'd8}, // R8 ack
    '{1'b1, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 4'd5}, // R5 1->1
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF, 1'b0, 4'd6}, // R6 fall
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h7FFF_FFFE, 1'b0, 4'd6},
    '{1'b1, 32'h9000_0000, 1'b1, 1'b1, 1'b0, 32'h9000_0000, 1'b1, 4'd9}, // R9 + R5
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'h9000_0000, 1'b0, 4'd8},
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'h9000_0000, 1'b0, 4'd8}, // R8 idle ack
    '{1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 4'd2},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'd8}, // R8 collide
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'd8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         tick = 1'b0;
  logic         ext_en = 1'b0;
  logic         ack = 1'b0;
  logic         irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dcount_irq #(.CNT_W(W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick    (tick),
    .ext_en  (ext_en),
    .ack     (ack),
    .irq_req (irq_req)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [W-1:0] wd, input logic tk,
                       input logic en, input logic ak);
    @(negedge clk);
    wr_en = we; wr_data = wd; tick = tk; ext_en = en; ack = ak;
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", rd_data, '0);
    check("R1", {{(W-1){1'b0}}, irq_req}, '0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1", rd_data, '0);
    check("R1", {{(W-1){1'b0}}, irq_req}, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].wd, VEC[i].tk, VEC[i].en, VEC[i].ak);
      check($sformatf("R%0d row %0d count", VEC[i].req, i), rd_data, VEC[i].exp_cnt);
      check($sformatf("R%0d row %0d irq", VEC[i].req, i),
            {{(W-1){1'b0}}, irq_req}, {{(W-1){1'b0}}, VEC[i].exp_irq});
    end

    // R5: write crossing from the low half into the top half
    drive(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
    check("R5 low write", {{(W-1){1'b0}}, irq_req}, '0);
    drive(1'b1, 32'hC000_0000, 1'b0, 1'b1, 1'b0);
    check("R5 crossing write", {{(W-1){1'b0}}, irq_req}, {{(W-1){1'b0}}, 1'b1});
    // R7: masked for several cycles, ticks inside top half keep it pending
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R7 masked", {{(W-1){1'b0}}, irq_req}, '0);
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R3 count", rd_data, 32'hBFFF_FFFE);
    drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R7 reappear", {{(W-1){1'b0}}, irq_req}, {{(W-1){1'b0}}, 1'b1});

    // R1: reset while a request is pending
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; ack = 1'b0;
    #2;
    check("R1 mid reset count", rd_data, '0);
    check("R1 mid reset irq", {{(W-1){1'b0}}, irq_req}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule